// File: doc/BRIEF.md
# Multi-level page table walker

The block turns a 64-bit input address into an output address. It does this by reading 64-bit descriptors from memory, level by level, through a table hierarchy of up to four levels. A requester supplies five things together with a one-cycle `start` strobe:

- the already-selected table base;
- a granule code (4 KB, 16 KB or 64 KB pages);
- the region-size field `tsz`;
- the input address;
- the access type (read or write).

The walker issues one 8-byte descriptor read at a time on a plain request/response port. It decodes each returned word as a table, a block, a page or an invalid entry, and checks permissions at every level.

A walk ends with a one-cycle `done` or a one-cycle `fault`. After `done`, the result registers hold the output address, the mapping-size mask and the granted permissions. After `fault`, they hold a fault kind and the address of the descriptor that caused it. The walker then returns to idle.

The walker assumes two things about its inputs. First, `tsz` lies between 16 and 39, which gives an input size of 25 to 48 bits. Second, the memory answers every request with exactly one response.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `done` and `fault` are low and `out_perm` is 0.
- R2: The step from the index to the granule shift is the stride, which equals the granule shift minus 3. The granule shift is 12, 14 or 16 for `gran` = 0, 1 or 2. The input size is 64 − `tsz`. The first level read is 4 − (input size − 4) / stride.
- R3: The first table base is `ttb[47:0]` with its low bits cleared. The number of cleared bits is the input size minus stride × (4 − first level).
- R4: Each descriptor is read at table base + 8 × index. The index is the input-address field that starts at that level's shift. No new request is issued while one is outstanding.
- R5: A response with `mem_rsp_err` high ends the walk with `fault_kind` 3 (external abort), and `fault_addr` equals the address of that read.
- R6: These descriptors end the walk with `fault_kind` 1 (translation), and `fault_addr` is the descriptor address:
  - a descriptor with bit 0 clear;
  - a descriptor at level 3 with bit 1 clear;
  - a descriptor at level 0 with bit 1 clear.
- R7: A leaf is one of two descriptor types:
  - at level 3, a descriptor with bits 1:0 = 11 (page);
  - at level 1 or 2, a descriptor with bits 1:0 = 01 (block).

  A leaf gives `done` and a mapping of size 2^shift for its level. `out_mask` is 2^shift − 1, and `out_addr` is descriptor bits 47:shift plus the input-address bits below shift.
- R8: Leaf bit 7 set means read-only. A write to a read-only leaf gives `fault_kind` 2 (permission). On `done`, `out_perm` is {write, read}, with read = 1 and write = ~bit 7.
- R9: A table descriptor (bits 1:0 = 11 at levels 0 to 2) with bit 62 set makes a write access fault with `fault_kind` 2 at that descriptor. A read access passes the table and continues at the next level. The next base is descriptor bits 47:granule shift.
- R10: On every fault `out_perm` is 0. `done` and `fault` are never high together, each lasts one cycle, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| ttb | input | 64 | Selected table base register |
| gran | input | 2 | Granule code: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB |
| tsz | input | 6 | Region size field |
| iova | input | 64 | Input address to translate |
| wr | input | 1 | 1 = write access, 0 = read |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request (one cycle) |
| mem_addr | output | PA_W | Descriptor read address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Returned descriptor |
| mem_rsp_err | input | 1 | Bus error on this read |
| done | output | 1 | Walk finished with a translation |
| fault | output | 1 | Walk finished with a fault |
| fault_kind | output | 2 | 0 none, 1 translation, 2 permission, 3 external abort |
| fault_addr | output | PA_W | Descriptor address of the fault |
| out_addr | output | PA_W | Translated address |
| out_mask | output | PA_W | Mask of offset bits below the mapping size |
| out_perm | output | 2 | {write, read} granted permissions |

## Verification
Four outcomes are hard to reach from the ports, because each needs a particular descriptor at a particular level of a walk that is already in progress:
- a bus error partway through a walk;
- a write-protected table that sits above a perfectly good leaf;
- a level-0 block;
- the start-level arithmetic at the 16 KB and 64 KB granules.

The bench holds a fixed memory image with tables for all three granules and one address that always answers with an error. Each vector's input address is chosen so that its index fields steer the walk to the wanted entry. Each vector also checks the first descriptor address, which exposes errors in the start-level and base-clearing arithmetic.

// File: rtl/ptw_pkg.sv
// Package: shared encodings and level arithmetic for the page table walker.
// Assumes granule shift <= 16 and level shifts that fit in 6 bits.
package ptw_pkg;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_XLATE = 2'd1,
        FK_PERM  = 2'd2,
        FK_ABORT = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ISSUE,
        ST_WAIT
    } state_e;

    typedef enum logic [1:0] {
        DK_BAD,
        DK_TABLE,
        DK_LEAF
    } dkind_e;

    localparam int DBIT_VALID = 0;
    localparam int DBIT_TYPE  = 1;
    localparam int DBIT_RO    = 7;
    localparam int DBIT_TWP   = 62;

    // Address bit where the index of a level starts.
    function automatic logic [5:0] lvl_shift(input logic [1:0] lvl,
                                             input logic [4:0] gshift,
                                             input logic [3:0] stride);
        logic [1:0] below;
        below = 2'd3 - lvl;
        return 6'(gshift) + 6'(below) * 6'(stride);
    endfunction

endpackage

// File: rtl/ptw_geom.sv
// Module: derives the walk geometry from the granule code and region size.
// Assumes tsz in 16..39 so the first level lies in 0..3.
module ptw_geom (
    input  logic [1:0] gran,
    input  logic [5:0] tsz,
    output logic [4:0] gshift,
    output logic [3:0] stride,
    output logic [6:0] insize,
    output logic [1:0] start_lvl,
    output logic [6:0] clear_w
);
    logic [6:0] levels;

    // Granule shift, stride, level count and base clearing width.
    always_comb begin
        case (gran)
            2'd1:    gshift = 5'd14;
            2'd2:    gshift = 5'd16;
            default: gshift = 5'd12;
        endcase
        stride    = 4'(gshift - 5'd3);
        insize    = 7'd64 - 7'(tsz);
        levels    = (insize - 7'd4) / 7'(stride);
        start_lvl = 2'(3'd4 - 3'(levels));
        clear_w   = insize - 7'(levels * 7'(stride));
    end
endmodule

// File: rtl/ptw_decode.sv
// Module: classifies one descriptor at a given level and extracts its fields.
// Assumes PA_W <= 61 so the table write-protect bit lies above the address.
module ptw_decode
    import ptw_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic [63:0]     desc,
    input  logic [1:0]      lvl,
    input  logic [4:0]      gshift,
    input  logic [5:0]      lshift,
    output dkind_e          kind,
    output logic            ro,
    output logic            twp,
    output logic [PA_W-1:0] next_base,
    output logic [PA_W-1:0] leaf_base
);
    localparam logic [PA_W-1:0] ONE = 1;

    logic unused_desc_hi;
    assign unused_desc_hi = ^{desc[63], desc[61:PA_W]};

    // Descriptor type from the valid and type bits and the level.
    always_comb begin
        if (!desc[DBIT_VALID])
            kind = DK_BAD;
        else if (lvl == 2'd3)
            kind = desc[DBIT_TYPE] ? DK_LEAF : DK_BAD;
        else if (desc[DBIT_TYPE])
            kind = DK_TABLE;
        else
            kind = (lvl == 2'd0) ? DK_BAD : DK_LEAF;
    end

    // Permission bits and the two forms of output address.
    always_comb begin
        ro        = desc[DBIT_RO];
        twp       = desc[DBIT_TWP];
        next_base = desc[PA_W-1:0] & ~((ONE << gshift) - ONE);
        leaf_base = desc[PA_W-1:0] & ~((ONE << lshift) - ONE);
    end
endmodule

// File: rtl/ptw_walker.sv
// Module: multi-level page table walker. It runs one walk at a time with a
// single outstanding descriptor read and ends in a one-cycle done or fault.
// Assumes the memory returns exactly one response per request.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [63:0]     ttb,
    input  logic [1:0]      gran,
    input  logic [5:0]      tsz,
    input  logic [63:0]     iova,
    input  logic            wr,
    output logic            busy,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            done,
    output logic            fault,
    output logic [1:0]      fault_kind,
    output logic [PA_W-1:0] fault_addr,
    output logic [PA_W-1:0] out_addr,
    output logic [PA_W-1:0] out_mask,
    output logic [1:0]      out_perm
);
    localparam int VA_W    = 64;
    localparam int ENTRY_B = 8;
    localparam int IDX_SH  = $clog2(ENTRY_B);
    localparam logic [PA_W-1:0] ONE = 1;
    localparam logic [VA_W-1:0] VONE = 1;

    state_e          state;
    logic [1:0]      lvl;
    logic [PA_W-1:0] base, req_addr_q, ttb_q;
    logic [VA_W-1:0] iova_q;
    logic            wr_q;
    logic [1:0]      gran_q;
    logic [5:0]      tsz_q;

    logic [4:0]      gshift;
    logic [3:0]      stride;
    logic [6:0]      insize, clear_w;
    logic [1:0]      start_lvl;
    logic [5:0]      lshift;
    logic [VA_W-1:0] iova_in, idx;
    logic [PA_W-1:0] desc_addr, lmask;

    dkind_e          kind;
    logic            d_ro, d_twp;
    logic [PA_W-1:0] next_base, leaf_base;

    logic            res_fault, res_done, res_descend;
    fault_e          res_kind;

    logic unused_ttb_hi;
    assign unused_ttb_hi = ^ttb[63:PA_W];

    ptw_geom u_geom (
        .gran      (gran_q),
        .tsz       (tsz_q),
        .gshift    (gshift),
        .stride    (stride),
        .insize    (insize),
        .start_lvl (start_lvl),
        .clear_w   (clear_w)
    );

    ptw_decode #(.PA_W(PA_W)) u_dec (
        .desc      (mem_rsp_data),
        .lvl       (lvl),
        .gshift    (gshift),
        .lshift    (lshift),
        .kind      (kind),
        .ro        (d_ro),
        .twp       (d_twp),
        .next_base (next_base),
        .leaf_base (leaf_base)
    );

    // Index and descriptor address for the current level.
    always_comb begin
        lshift    = lvl_shift(lvl, gshift, stride);
        iova_in   = iova_q & ((VONE << insize) - VONE);
        idx       = (iova_in >> lshift) & ((VONE << stride) - VONE);
        desc_addr = base + PA_W'(idx << IDX_SH);
        lmask     = (ONE << lshift) - ONE;
    end

    // Outcome of the response that is arriving.
    always_comb begin
        res_fault   = 1'b0;
        res_done    = 1'b0;
        res_descend = 1'b0;
        res_kind    = FK_NONE;
        if (state == ST_WAIT && mem_rsp_valid) begin
            if (mem_rsp_err) begin
                res_fault = 1'b1;
                res_kind  = FK_ABORT;
            end else if (kind == DK_BAD) begin
                res_fault = 1'b1;
                res_kind  = FK_XLATE;
            end else if (kind == DK_LEAF) begin
                if (wr_q && d_ro) begin
                    res_fault = 1'b1;
                    res_kind  = FK_PERM;
                end else begin
                    res_done = 1'b1;
                end
            end else if (wr_q && d_twp) begin
                res_fault = 1'b1;
                res_kind  = FK_PERM;
            end else begin
                res_descend = 1'b1;
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign mem_req  = (state == ST_ISSUE);
    assign mem_addr = desc_addr;

    // Walk sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lvl        <= 2'd0;
            base       <= '0;
            req_addr_q <= '0;
            ttb_q      <= '0;
            iova_q     <= '0;
            wr_q       <= 1'b0;
            gran_q     <= 2'd0;
            tsz_q      <= 6'd16;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_kind <= FK_NONE;
            fault_addr <= '0;
            out_addr   <= '0;
            out_mask   <= '0;
            out_perm   <= 2'b00;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    ttb_q  <= ttb[PA_W-1:0];
                    iova_q <= iova;
                    wr_q   <= wr;
                    gran_q <= gran;
                    tsz_q  <= tsz;
                    state  <= ST_SETUP;
                end
                ST_SETUP: begin
                    lvl   <= start_lvl;
                    base  <= ttb_q & ~((ONE << clear_w) - ONE);
                    state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    req_addr_q <= desc_addr;
                    state      <= ST_WAIT;
                end
                default: begin
                    if (res_descend) begin
                        base  <= next_base;
                        lvl   <= lvl + 2'd1;
                        state <= ST_ISSUE;
                    end else if (res_fault) begin
                        fault      <= 1'b1;
                        fault_kind <= res_kind;
                        fault_addr <= req_addr_q;
                        out_addr   <= '0;
                        out_mask   <= '0;
                        out_perm   <= 2'b00;
                        state      <= ST_IDLE;
                    end else if (res_done) begin
                        done       <= 1'b1;
                        fault_kind <= FK_NONE;
                        out_addr   <= leaf_base + (iova_q[PA_W-1:0] & lmask);
                        out_mask   <= lmask;
                        out_perm   <= {~d_ro, 1'b1};
                        state      <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Checker: port-level properties of the walker, bound to every instance.
module ptw_walker_chk #(
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic            fault,
    input logic [1:0]      fault_kind,
    input logic [PA_W-1:0] fault_addr,
    input logic [PA_W-1:0] out_mask,
    input logic [1:0]      out_perm
);
    logic            pending;
    logic [PA_W-1:0] last_addr;

    // Tracks the outstanding read and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            last_addr <= '0;
        end else begin
            if (mem_req) begin
                pending   <= 1'b1;
                last_addr <= mem_addr;
            end else if (mem_rsp_valid) begin
                pending <= 1'b0;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !mem_req && !done && !fault && out_perm == 2'b00));

    assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pending);

    assert_req_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_abort_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_kind == 2'd3) |-> fault_addr == last_addr);

    assert_mask_low_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((out_mask & (out_mask + 1'b1)) == '0));

    assert_fault_noperm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> out_perm == 2'b00);

    assert_exclusive_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> (!done && !fault));

    assert_idle_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !busy);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .fault_kind    (fault_kind),
    .fault_addr    (fault_addr),
    .out_mask      (out_mask),
    .out_perm      (out_perm)
);

// File: tb/tb_ptw_walker.sv
// Bench: fixed memory image, vector table walked by one loop, then directed checks.
module tb_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W = 48;
    localparam int NV = 13;
    localparam logic [47:0] ERR_ADDR = 48'h1020;

    typedef struct packed {
        logic [1:0]  gran;
        logic [5:0]  tsz;
        logic [63:0] ttb;
        logic [63:0] iova;
        logic        wr;
        logic [1:0]  kind;
        logic [47:0] addr;
        logic [47:0] mask;
        logic [1:0]  perm;
        logic [47:0] first;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // 4K, tsz 25, ttb with stray high and low bits (R3): page, rw
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h123,        1'b0, 2'd0, 48'h7123,      48'hFFF,       2'b11, 48'h1000},
        // write to a read-only page (R8)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h1456,       1'b1, 2'd2, 48'h5008,      48'h0,         2'b00, 48'h1000},
        // read of the read-only page (R8)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h1456,       1'b0, 2'd0, 48'h8456,      48'hFFF,       2'b01, 48'h1000},
        // level-3 entry with the type bit clear (R6)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h2000,       1'b0, 2'd1, 48'h5010,      48'h0,         2'b00, 48'h1000},
        // level-2 block, 2 MB (R7)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h21_2345,    1'b1, 2'd0, 48'h61_2345,   48'h1F_FFFF,   2'b11, 48'h1000},
        // level-1 block, 1 GB, read-only (R7)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h4ABC_DEF0,  1'b0, 2'd0, 48'h4ABC_DEF0, 48'h3FFF_FFFF, 2'b01, 48'h1008},
        // invalid level-1 entry (R6)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h8000_0000,  1'b0, 2'd1, 48'h1010,      48'h0,         2'b00, 48'h1010},
        // write through a write-protected table (R9)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'hC000_0000,  1'b1, 2'd2, 48'h1018,      48'h0,         2'b00, 48'h1018},
        // read through the same table reaches a level-2 block (R9)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'hC000_0777,  1'b0, 2'd0, 48'h80_0777,   48'h1F_FFFF,   2'b11, 48'h1018},
        // bus error on the level-1 read (R5)
        '{2'd0, 6'd25, 64'hFFFF_0000_0000_1ABC, 64'h1_0000_0000, 1'b0, 2'd3, 48'h1020,     48'h0,         2'b00, 48'h1020},
        // 64K granule, start level 2 (R2)
        '{2'd2, 6'd22, 64'h1_0000,              64'h2002_1234,  1'b1, 2'd0, 48'h3_1234,    48'hFFFF,      2'b11, 48'h1_0008},
        // 16K granule, level-2 block 32 MB (R2)
        '{2'd1, 6'd28, 64'h4_0123,              64'h0155_5555,  1'b0, 2'd0, 48'h555_5555,  48'h1FF_FFFF,  2'b01, 48'h4_0000},
        // 4K tsz 16 starts at level 0; a block there is rejected (R6)
        '{2'd0, 6'd16, 64'h6000,                64'h0,          1'b0, 2'd1, 48'h6000,      48'h0,         2'b00, 48'h6000}
    };

    localparam string TAGS [NV] = '{"R3", "R8", "R8", "R6", "R7", "R7", "R6",
                                     "R9", "R9", "R5", "R2", "R2", "R6"};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [63:0]     ttb = '0;
    logic [1:0]      gran = '0;
    logic [5:0]      tsz = 6'd25;
    logic [63:0]     iova = '0;
    logic            wr = 1'b0;
    logic            busy, mem_req, done, fault;
    logic [PA_W-1:0] mem_addr, fault_addr, out_addr, out_mask;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            mem_rsp_err = 1'b0;
    logic [1:0]      fault_kind, out_perm;

    int n_checks = 0;
    int n_fails  = 0;
    int req_cnt  = 0;
    logic [47:0] req_log [0:255];
    bit summary_done = 1'b0;
    logic [63:0] mem [logic [47:0]];

    ptw_walker #(.PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ttb(ttb), .gran(gran),
        .tsz(tsz), .iova(iova), .wr(wr), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .fault(fault), .fault_kind(fault_kind),
        .fault_addr(fault_addr), .out_addr(out_addr), .out_mask(out_mask),
        .out_perm(out_perm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: answers each request one cycle later and logs its address.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (mem_req) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_err   <= (mem_addr == ERR_ADDR);
            mem_rsp_data  <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
            req_log[req_cnt[7:0]] <= mem_addr;
            req_cnt <= req_cnt + 1;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic run_vec(input int i);
        int c0;
        int waited;
        vec_t v;
        v = VECS[i];
        @(negedge clk);
        c0    = req_cnt;
        ttb   = v.ttb;
        gran  = v.gran;
        tsz   = v.tsz;
        iova  = v.iova;
        wr    = v.wr;
        start = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        waited = 0;
        while (!(done || fault) && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 200) begin
            check(TAGS[i], "walk timeout", 64'd0, 64'd1);
        end else begin
            check("R4", "first descriptor address", 64'(req_log[c0[7:0]]), 64'(v.first));
            check(TAGS[i], "fault kind", 64'(fault_kind), 64'(v.kind));
            check(TAGS[i], "permissions", 64'(out_perm), 64'(v.perm));
            if (v.kind == 2'd0) begin
                check(TAGS[i], "done flag", 64'(done), 64'd1);
                check(TAGS[i], "output address", 64'(out_addr), 64'(v.addr));
                check(TAGS[i], "output mask", 64'(out_mask), 64'(v.mask));
            end else begin
                check("R10", "fault flag", 64'(fault), 64'd1);
                check(TAGS[i], "fault address", 64'(fault_addr), 64'(v.addr));
            end
            check("R10", "busy low at end", 64'(busy), 64'd0);
            @(negedge clk);
            check("R10", "end strobe one cycle", 64'({done, fault}), 64'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        mem[48'h1000]  = 64'h2003;
        mem[48'h1008]  = 64'h4000_0081;
        mem[48'h1010]  = 64'h0;
        mem[48'h1018]  = 64'h4000_0000_0000_3003;
        mem[48'h2000]  = 64'h5003;
        mem[48'h2008]  = 64'h60_0001;
        mem[48'h3000]  = 64'h80_0001;
        mem[48'h5000]  = 64'h7003;
        mem[48'h5008]  = 64'h8083;
        mem[48'h5010]  = 64'h9001;
        mem[48'h6000]  = 64'h1;
        mem[48'h10008] = 64'h2_0003;
        mem[48'h20010] = 64'h3_0003;
        mem[48'h40000] = 64'h400_0081;

        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "busy after reset", 64'(busy), 64'd0);
        check("R1", "request after reset", 64'(mem_req), 64'd0);
        check("R1", "end strobes after reset", 64'({done, fault}), 64'd0);
        check("R1", "permissions after reset", 64'(out_perm), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after release", 64'(busy), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R4: a full 4K walk from level 1 makes three reads at known addresses
        begin
            int c0;
            c0 = req_cnt;
            run_vec(0);
            check("R4", "read count of a three-level walk", 64'(req_cnt - c0), 64'd3);
            check("R4", "second descriptor address", 64'(req_log[8'(c0 + 1)]), 64'h2000);
            check("R4", "third descriptor address", 64'(req_log[8'(c0 + 2)]), 64'h5000);
        end

        // R1: reset in the middle of a walk returns to idle
        @(negedge clk);
        ttb = 64'h1000; gran = 2'd0; tsz = 6'd25; iova = 64'h123; wr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "idle after mid-walk reset", 64'(busy), 64'd0);

        finish_run();
    end
endmodule